// File: doc/BRIEF.md
# Receive Packet Filter for a Shared Serial Bus Link Layer

Every packet sent on a shared serial bus reaches every attached node, so each node's link layer must decide for itself which packets it keeps. This block makes that decision from a header descriptor that the receive path presents for one cycle. A packet is handled in one of two ways. An addressed (asynchronous) packet is kept when its 6-bit destination equals the node's own programmable ID, or equals the all-ones broadcast ID 63. A channel (isochronous) packet is kept when its 6-bit channel number is set in a 64-bit listen mask.

One cycle after the header, the block reports a verdict. This is accept or reject, together with an acknowledge request and a 4-bit code. Only addressed packets sent to this node alone are acknowledged. The code tells the sender whether the write finished, whether a read or lock is pending, or whether it must retry because the receive buffer was full or a CRC error was flagged. Broadcast and channel packets are never acknowledged. Payload beats that follow an accepted header pass to the forward port with one cycle of delay. Payload beats that follow a rejected header are dropped.

Top module: `rxf_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `vrd_valid`, `ack_req` and `fwd_valid` are low.
- R2: For each cycle with `hdr_valid` high, `vrd_valid` is high in the next cycle and in no other cycle. `ack_req` is high only when `vrd_valid` is high, and `ack_code` is 0 whenever `ack_req` is low.
- R3: An addressed packet (`hdr_iso`=0) with `hdr_dest` equal to `node_id` and not 63 is accepted when `hdr_crc_err`=0 and `buf_full`=0. The acknowledge code then depends on `hdr_op`: 1 (complete) for op 0 (write) and op 3 (write-class), and 2 (pending) for op 1 (read) and op 2 (lock).
- R4: An addressed packet whose destination is neither `node_id` nor 63 is rejected, and no acknowledge is requested.
- R5: A packet addressed to this node alone with `buf_full`=1 and `hdr_crc_err`=0 is rejected and acknowledged with code 4 (busy, retry).
- R6: A packet addressed to this node alone with `hdr_crc_err`=1 is rejected and acknowledged with code 13 (data error, retry). The CRC error takes priority over `buf_full`.
- R7: A broadcast packet (destination 63) is accepted only when `hdr_crc_err`=0 and `buf_full`=0. It is never acknowledged, whatever its error state.
- R8: A channel packet (`hdr_iso`=1) is accepted only when `chan_mask[hdr_chan]`=1, `hdr_crc_err`=0 and `buf_full`=0. It is never acknowledged.
- R9: A payload beat given while the gate is open appears on `fwd_*` one cycle later. Its data and last flag are unchanged. The gate opens on an accepted header and closes on a rejected header or after a beat with `pl_last`=1. Beats given while the gate is closed never reach `fwd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 6 | Local node ID, 0 to 62 |
| chan_mask | input | 64 | Listen mask: bit n enables channel n |
| hdr_valid | input | 1 | Header descriptor present this cycle |
| hdr_iso | input | 1 | 1 = channel packet, 0 = addressed packet |
| hdr_dest | input | 6 | Destination node ID (63 = broadcast) |
| hdr_chan | input | 6 | Channel number |
| hdr_op | input | 2 | 0 write, 1 read, 2 lock, 3 write-class |
| hdr_crc_err | input | 1 | Packet arrived with a CRC error |
| buf_full | input | 1 | Receive buffer has no room |
| pl_valid | input | 1 | Payload beat present |
| pl_data | input | 32 | Payload beat data |
| pl_last | input | 1 | Final beat of the packet |
| vrd_valid | output | 1 | Verdict present (one cycle after header) |
| vrd_accept | output | 1 | Packet kept |
| ack_req | output | 1 | Send an acknowledgement |
| ack_code | output | 4 | 1 complete, 2 pending, 4 busy, 13 data error |
| fwd_valid | output | 1 | Forwarded payload beat present |
| fwd_data | output | 32 | Forwarded payload data |
| fwd_last | output | 1 | Forwarded final beat |

## Verification
Two internal faults would show at the ports. A wrong match result or a wrong verdict priority shows on the very next cycle, as a wrong `vrd_accept`, `ack_req` or `ack_code` for that header. A stale gate shows one cycle after the next payload beat: the beat either leaks onto `fwd_valid` after a rejected header or is lost after an accepted one. The bench drives every destination, operation, error and full combination for several node IDs, and every channel under two masks. It checks each verdict in the cycle it appears, and it runs accepted and rejected payload bursts through the gate.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int NODE_W_DEF = 6;
    localparam int CHAN_W_DEF = 6;
    localparam int DATA_W_DEF = 32;

    typedef enum logic [3:0] {
        ACK_NONE     = 4'd0,
        ACK_COMPLETE = 4'd1,
        ACK_PENDING  = 4'd2,
        ACK_BUSY     = 4'd4,
        ACK_DATA_ERR = 4'd13
    } ack_code_e;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_READ   = 2'd1,
        OP_LOCK   = 2'd2,
        OP_WRCLS  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_LOCAL = 2'd1,
        TGT_BCAST = 2'd2
    } target_e;

    typedef struct packed {
        logic      accept;
        logic      ack;
        ack_code_e code;
    } verdict_t;

    function automatic ack_code_e code_for_op(input op_e op);
        case (op)
            OP_READ, OP_LOCK: return ACK_PENDING;
            default:          return ACK_COMPLETE;
        endcase
    endfunction

    function automatic verdict_t decide(
        input logic    iso,
        input target_e tgt,
        input logic    chan_hit,
        input op_e     op,
        input logic    crc_err,
        input logic    full
    );
        verdict_t v;
        v.accept = 1'b0;
        v.ack    = 1'b0;
        v.code   = ACK_NONE;
        if (iso) begin
            v.accept = chan_hit && !crc_err && !full;
        end else begin
            case (tgt)
                TGT_BCAST: v.accept = !crc_err && !full;
                TGT_LOCAL: begin
                    v.ack = 1'b1;
                    if (crc_err) begin
                        v.code = ACK_DATA_ERR;
                    end else if (full) begin
                        v.code = ACK_BUSY;
                    end else begin
                        v.accept = 1'b1;
                        v.code   = code_for_op(op);
                    end
                end
                default: ;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
    import rxf_pkg::*;
#(
    parameter int NODE_W = NODE_W_DEF
) (
    input  logic [NODE_W-1:0] dest,
    input  logic [NODE_W-1:0] self_id,
    output target_e           tgt
);
    localparam logic [NODE_W-1:0] BCAST_ID = '1;

    always_comb begin
        if (dest == BCAST_ID) begin
            tgt = TGT_BCAST;
        end else if (dest == self_id) begin
            tgt = TGT_LOCAL;
        end else begin
            tgt = TGT_NONE;
        end
    end
endmodule

// File: rtl/rxf_chan_match.sv
module rxf_chan_match #(
    parameter int CHAN_W = 6,
    parameter int CHAN_N = 1 << CHAN_W
) (
    input  logic [CHAN_N-1:0] mask,
    input  logic [CHAN_W-1:0] chan,
    output logic              hit
);
    logic [CHAN_N-1:0] sel;

    for (genvar i = 0; i < CHAN_N; i++) begin : g_sel
        assign sel[i] = mask[i] && (chan == CHAN_W'(i));
    end

    assign hit = |sel;
endmodule

// File: rtl/rxf_fwd_gate.sv
module rxf_fwd_gate #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_evt,
    input  logic              open_val,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else if (open_evt) begin
            gate_q <= open_val;
        end else if (in_valid && in_last) begin
            gate_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= in_valid && gate_q;
            out_data  <= in_data;
            out_last  <= in_last && in_valid && gate_q;
        end
    end
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter
    import rxf_pkg::*;
#(
    parameter int NODE_W = NODE_W_DEF,
    parameter int CHAN_W = CHAN_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int CHAN_N = 1 << CHAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NODE_W-1:0] node_id,
    input  logic [CHAN_N-1:0] chan_mask,
    input  logic              hdr_valid,
    input  logic              hdr_iso,
    input  logic [NODE_W-1:0] hdr_dest,
    input  logic [CHAN_W-1:0] hdr_chan,
    input  logic [1:0]        hdr_op,
    input  logic              hdr_crc_err,
    input  logic              buf_full,
    input  logic              pl_valid,
    input  logic [DATA_W-1:0] pl_data,
    input  logic              pl_last,
    output logic              vrd_valid,
    output logic              vrd_accept,
    output logic              ack_req,
    output logic [3:0]        ack_code,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              fwd_last
);
    target_e  tgt;
    logic     chan_hit;
    verdict_t vd;

    rxf_addr_match #(.NODE_W(NODE_W)) addr_i (
        .dest    (hdr_dest),
        .self_id (node_id),
        .tgt     (tgt)
    );

    rxf_chan_match #(.CHAN_W(CHAN_W), .CHAN_N(CHAN_N)) chan_i (
        .mask (chan_mask),
        .chan (hdr_chan),
        .hit  (chan_hit)
    );

    assign vd = decide(hdr_iso, tgt, chan_hit, op_e'(hdr_op), hdr_crc_err, buf_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            vrd_valid  <= 1'b0;
            vrd_accept <= 1'b0;
            ack_req    <= 1'b0;
            ack_code   <= ACK_NONE;
        end else begin
            vrd_valid  <= hdr_valid;
            vrd_accept <= hdr_valid && vd.accept;
            ack_req    <= hdr_valid && vd.ack;
            ack_code   <= (hdr_valid && vd.ack) ? vd.code : ACK_NONE;
        end
    end

    rxf_fwd_gate #(.DATA_W(DATA_W)) gate_i (
        .clk       (clk),
        .rst       (rst),
        .open_evt  (hdr_valid),
        .open_val  (vd.accept),
        .in_valid  (pl_valid),
        .in_data   (pl_data),
        .in_last   (pl_last),
        .out_valid (fwd_valid),
        .out_data  (fwd_data),
        .out_last  (fwd_last)
    );
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
    parameter int NODE_W = 6,
    parameter int CHAN_W = 6,
    parameter int DATA_W = 32,
    parameter int CHAN_N = 1 << CHAN_W
) (
    input logic              clk,
    input logic              rst,
    input logic [NODE_W-1:0] node_id,
    input logic [CHAN_N-1:0] chan_mask,
    input logic              hdr_valid,
    input logic              hdr_iso,
    input logic [NODE_W-1:0] hdr_dest,
    input logic [CHAN_W-1:0] hdr_chan,
    input logic [1:0]        hdr_op,
    input logic              hdr_crc_err,
    input logic              buf_full,
    input logic              pl_valid,
    input logic [DATA_W-1:0] pl_data,
    input logic              pl_last,
    input logic              vrd_valid,
    input logic              vrd_accept,
    input logic              ack_req,
    input logic [3:0]        ack_code,
    input logic              fwd_valid,
    input logic [DATA_W-1:0] fwd_data,
    input logic              fwd_last
);
    localparam logic [NODE_W-1:0] BC = '1;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!vrd_valid && !ack_req && !fwd_valid));

    a_r2_verdict_follows_hdr: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> vrd_valid);

    a_r2_no_spurious_verdict: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> !vrd_valid);

    a_r2_ack_within_verdict: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> vrd_valid);

    a_r4_no_ack_foreign: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !hdr_iso && hdr_dest != node_id && hdr_dest != BC)
        |=> (!vrd_accept && !ack_req));

    a_r5_busy_when_full: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !hdr_iso && hdr_dest == node_id && hdr_dest != BC
         && !hdr_crc_err && buf_full)
        |=> (ack_req && ack_code == 4'd4 && !vrd_accept));

    a_r6_crc_error_ack: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !hdr_iso && hdr_dest == node_id && hdr_dest != BC && hdr_crc_err)
        |=> (ack_req && ack_code == 4'd13 && !vrd_accept));

    a_r7_r8_never_acked: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && (hdr_iso || hdr_dest == BC)) |=> !ack_req);

    a_r8_chan_off_rejected: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_iso && !chan_mask[hdr_chan]) |=> !vrd_accept);

    a_r9_fwd_from_beat: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> ($past(pl_valid) && fwd_data == $past(pl_data)));
endmodule

bind rxf_filter rxf_filter_chk #(
    .NODE_W(NODE_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W), .CHAN_N(CHAN_N)
) chk_i (.*);

// File: tb/rxf_filter_tb_top.sv
module rxf_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  node_id;
    logic [63:0] chan_mask;
    logic        hdr_valid, hdr_iso, hdr_crc_err, buf_full;
    logic [5:0]  hdr_dest, hdr_chan;
    logic [1:0]  hdr_op;
    logic        pl_valid, pl_last;
    logic [31:0] pl_data;
    logic        vrd_valid, vrd_accept, ack_req, fwd_valid, fwd_last;
    logic [3:0]  ack_code;
    logic [31:0] fwd_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rxf_filter dut_i (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Packed verdict: {vrd_valid, accept, ack_req, code}
    task automatic send_hdr(input bit iso, input logic [5:0] dest, input logic [5:0] ch,
                            input logic [1:0] op, input bit crc, input bit full,
                            input bit exp_acc, input bit exp_ack, input logic [3:0] exp_code,
                            input string tag);
        logic [6:0] act, exp;
        hdr_valid = 1; hdr_iso = iso; hdr_dest = dest; hdr_chan = ch;
        hdr_op = op; hdr_crc_err = crc; buf_full = full;
        @(posedge clk); @(negedge clk);
        hdr_valid = 0;
        act = {vrd_valid, vrd_accept, ack_req, ack_code};
        exp = {1'b1, exp_acc, exp_ack, exp_code};
        check(act == exp, tag, 64'(act), 64'(exp));
    endtask

    task automatic beat(input logic [31:0] d, input bit last, input bit exp_fwd, input string tag);
        logic [33:0] act, exp;
        pl_valid = 1; pl_data = d; pl_last = last;
        @(posedge clk); @(negedge clk);
        pl_valid = 0; pl_last = 0;
        act = {fwd_valid, fwd_valid ? fwd_last : 1'b0, fwd_valid ? fwd_data : 32'h0};
        exp = exp_fwd ? {1'b1, last, d} : 34'h0;
        check(act == exp, tag, 64'(act), 64'(exp));
    endtask

    initial begin
        logic [5:0] ids [3];
        logic [63:0] masks [2];
        ids[0] = 6'd0; ids[1] = 6'd37; ids[2] = 6'd62;
        masks[0] = 64'h8000_0000_0000_0001 | 64'h0000_F0F0_0000_1234;
        masks[1] = 64'h5555_AAAA_0FF0_C3C3;

        rst = 1; node_id = 0; chan_mask = '0;
        hdr_valid = 0; hdr_iso = 0; hdr_dest = 0; hdr_chan = 0; hdr_op = 0;
        hdr_crc_err = 0; buf_full = 0; pl_valid = 0; pl_data = 0; pl_last = 0;
        hdr_valid = 1;   // header during reset must not yield a verdict
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({vrd_valid, ack_req, fwd_valid} == 3'b0, "R1 reset",
              64'({vrd_valid, ack_req, fwd_valid}), 64'h0);
        hdr_valid = 0;
        rst = 0;
        @(posedge clk); @(negedge clk);
        check({vrd_valid, ack_req, fwd_valid} == 3'b0, "R1 after reset",
              64'({vrd_valid, ack_req, fwd_valid}), 64'h0);

        // Addressed packets: full sweep of destination, op, error and full
        for (int k = 0; k < 3; k++) begin
            node_id = ids[k];
            for (int d = 0; d < 64; d++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int c = 0; c < 2; c++) begin
                        for (int f = 0; f < 2; f++) begin
                            bit acc, ack; logic [3:0] code; string tag;
                            acc = 0; ack = 0; code = 4'd0;
                            if (d == 63) begin
                                tag = "R7 broadcast"; acc = (c == 0) && (f == 0);
                            end else if (d == int'(ids[k])) begin
                                ack = 1;
                                if (c == 1) begin tag = "R6 crc"; code = 4'd13; end
                                else if (f == 1) begin tag = "R5 busy"; code = 4'd4; end
                                else begin
                                    tag = "R3 local"; acc = 1;
                                    code = (op == 1 || op == 2) ? 4'd2 : 4'd1;
                                end
                            end else begin
                                tag = "R4 foreign";
                            end
                            send_hdr(0, 6'(d), 6'(d ^ 21), 2'(op), c[0], f[0], acc, ack, code, tag);
                        end
                    end
                end
            end
            // idle cycle: verdict must not repeat
            @(posedge clk); @(negedge clk);
            check({vrd_valid, ack_req, ack_code} == 6'h0, "R2 idle no verdict",
                  64'({vrd_valid, ack_req, ack_code}), 64'h0);
        end

        // Channel packets: every channel under two masks, error and full combos
        node_id = 6'd5;
        for (int m = 0; m < 2; m++) begin
            chan_mask = masks[m];
            for (int ch = 0; ch < 64; ch++) begin
                for (int cf = 0; cf < 4; cf++) begin
                    bit acc;
                    acc = ((masks[m] >> ch) & 64'h1) != 0 && cf == 0;
                    send_hdr(1, 6'd5, 6'(ch), 2'(ch), cf[1], cf[0], acc, 0, 4'd0, "R8 channel");
                end
            end
        end

        // Payload gating
        chan_mask = 64'h0000_0000_0000_0100;
        beat(32'hDEAD_0001, 1, 0, "R9 beat before any header");
        send_hdr(1, 6'd0, 6'd8, 2'd0, 0, 0, 1, 0, 4'd0, "R8 open gate");
        beat(32'h1111_0001, 0, 1, "R9 accepted beat 1");
        @(posedge clk); @(negedge clk);
        check(fwd_valid == 0, "R9 gap", 64'(fwd_valid), 64'h0);
        beat(32'h1111_0002, 0, 1, "R9 accepted beat 2");
        beat(32'h1111_0003, 1, 1, "R9 accepted last");
        beat(32'h1111_0004, 0, 0, "R9 beat after last");
        send_hdr(1, 6'd0, 6'd9, 2'd0, 0, 0, 0, 0, 4'd0, "R8 closed channel");
        beat(32'h2222_0001, 0, 0, "R9 rejected beat");
        beat(32'h2222_0002, 1, 0, "R9 rejected last");
        node_id = 6'd12;
        send_hdr(0, 6'd12, 6'd0, 2'd1, 0, 0, 1, 1, 4'd2, "R3 open by address");
        beat(32'h3333_0001, 1, 1, "R9 addressed beat");
        send_hdr(0, 6'd12, 6'd0, 2'd0, 0, 0, 1, 1, 4'd1, "R3 open again");
        send_hdr(0, 6'd40, 6'd0, 2'd0, 0, 0, 0, 0, 4'd0, "R4 closes gate");
        beat(32'h4444_0001, 1, 0, "R9 after reject overrides");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule